// File: doc/BRIEF.md
# Serial Timing-Reference Word Aligner

This block sits behind the bit-level decoder of a serial digital video receiver and runs on the recovered bit clock. It takes one decoded bit per clock, least significant bit of each word first, and turns the stream into 10-bit parallel words with a one-cycle word strobe. The word boundary is not known in advance. The block finds it by looking for the timing-reference preamble: a run of ten ones followed by twenty zeros, which is the word sequence 3FF, 000, 000 sent LSB first. Each time it sees this pattern, it restarts its divide-by-ten bit counter, so the next word begins on the bit right after the preamble.

The word that follows every preamble carries the identifier. The block flags that word with a start pulse. It reads bit 6 of the word to tell an end-of-active-video marker (bit 6 = 1) from a start-of-active-video marker (bit 6 = 0), and drives the line-timing output `h_flag` from it. When the upstream descrambler is bypassed, the identifier has no meaning, and the block then leaves `h_flag` where it is.

A two-state machine tracks the identifier. The states are:
- `ST_SEARCH`: no identifier is pending.
- `ST_ID_WAIT`: the next completed word is the identifier.

The transitions are:
- `preamble_seen`: `ST_SEARCH` to `ST_ID_WAIT`.
- `id_captured`: `ST_ID_WAIT` to `ST_SEARCH`, taken when that word is latched.
- `stay`: every other cycle.

A captured word is not driven straight out. It is re-sampled half a word period later, at bit phase 5, so the output changes away from the boundary where the shift register is read.

Top module: `sdi_trs_aligner`

## Requirements
- R1: While reset is asserted and until the first word is delivered, `word_out` is 0 and `word_vld`, `word_start` and `h_flag` are 0.
- R2: Bits form words LSB first: the first bit received after a word boundary becomes bit 0. In steady state `word_vld` is a one-cycle pulse every 10 clocks, and two strobes are never less than 10 clocks apart.
- R3: The preamble is detected at any bit position. The 10 bits right after its last zero form the next delivered word, unchanged.
- R4: A delivered word appears on `word_out` with `word_vld` high in the clock cycle after the 6th rising edge counted from the edge that sampled its last bit. This holds also when a preamble moves the boundary, in which case the cadence shifts at once.
- R5: A preamble that lands on the existing word boundary leaves the strobe spacing at exactly 10 clocks.
- R6: `word_start` is high only together with `word_vld`, and only for the first word after each preamble.
- R7: With bypass low, `h_flag` takes bit 6 of the word after the preamble (1 gives high, 0 gives low), changing only in the cycle that word is strobed.
- R8: With bypass high, `h_flag` keeps its value across preambles and identifiers, while words and `word_start` are still produced.
- R9: `word_out` changes only in cycles where `word_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Decoded serial bit, LSB of each word first |
| bypass | input | 1 | High when descrambling is bypassed; freezes `h_flag` |
| word_out | output | 10 | Deserialized parallel word |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |
| word_start | output | 1 | Marks the first word after a preamble |
| h_flag | output | 1 | Line timing: high after end marker, low after start marker |

## Verification
The assertions check the following on every cycle:
- the bit counter stays in range;
- strobes are at least ten clocks apart;
- `word_start` never appears without `word_vld`;
- `word_out` holds between strobes;
- `h_flag` moves only on a start-flagged word and never while bypass is high.

Other behaviour can only be shown by the bench's scenarios:
- whether the realigned words carry the right bits;
- the exact latency from a realigning preamble to the identifier word;
- that an aligned preamble leaves the cadence untouched;
- that bit 6 selects the right `h_flag` level.

// File: rtl/sdi_trs_pkg.sv
package sdi_trs_pkg;
    typedef enum logic [0:0] {
        ST_SEARCH  = 1'b0,
        ST_ID_WAIT = 1'b1
    } trs_state_t;
endpackage

// File: rtl/trs_window.sv
module trs_window #(
    parameter int WORD_W    = 10,
    parameter int PRE_WORDS = 3,
    localparam int WIN_W    = WORD_W * PRE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic              pre_hit,
    output logic [WORD_W-1:0] nxt_word
);
    localparam logic [WIN_W-1:0] PRE_PAT = {{(WIN_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= {bit_in, win_q[WIN_W-1:1]};
    end

    assign pre_hit  = (win_q == PRE_PAT);
    assign nxt_word = {bit_in, win_q[WIN_W-1:WIN_W-WORD_W+1]};
endmodule

// File: rtl/trs_bit_phase.sv
module trs_bit_phase #(
    parameter int WORD_W    = 10,
    parameter int SAMPLE_PT = 5,
    localparam int CW       = $clog2(WORD_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_hit,
    output logic cap_en,
    output logic mid_en
);
    logic [CW-1:0] cnt_q, cnt_nx;

    always_comb begin
        if (pre_hit)                          cnt_nx = CW'(1);
        else if (cnt_q == CW'(WORD_W - 1))    cnt_nx = '0;
        else                                  cnt_nx = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end

    assign cap_en = (cnt_nx == '0);
    assign mid_en = (cnt_nx == CW'(SAMPLE_PT));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(WORD_W));

    // R3
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/trs_word_fsm.sv
module trs_word_fsm
    import sdi_trs_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int ID_BIT = 6,
    localparam int GW    = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic              pre_hit,
    input  logic              cap_en,
    input  logic              mid_en,
    input  logic [WORD_W-1:0] nxt_word,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              word_start,
    output logic              h_flag
);
    trs_state_t        state_q, state_nx;
    logic [WORD_W-1:0] cap_q;
    logic              cap_first_q;
    logic              pend_q;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SEARCH:  if (pre_hit) state_nx = ST_ID_WAIT;
            ST_ID_WAIT: if (cap_en)  state_nx = ST_SEARCH;
            default:                 state_nx = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q       <= '0;
            cap_first_q <= 1'b0;
            pend_q      <= 1'b0;
            word_out    <= '0;
            word_vld    <= 1'b0;
            word_start  <= 1'b0;
            h_flag      <= 1'b0;
        end else begin
            word_vld   <= 1'b0;
            word_start <= 1'b0;
            if (cap_en) begin
                cap_q       <= nxt_word;
                cap_first_q <= (state_q == ST_ID_WAIT);
                pend_q      <= 1'b1;
            end else if (mid_en && pend_q) begin
                pend_q     <= 1'b0;
                word_out   <= cap_q;
                word_vld   <= 1'b1;
                word_start <= cap_first_q;
                if (cap_first_q && !bypass) h_flag <= cap_q[ID_BIT];
            end
        end
    end

    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap_q <= GW'(WORD_W);
        else if (word_vld)              gap_q <= '0;
        else if (gap_q < GW'(WORD_W))   gap_q <= gap_q + GW'(1);
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (gap_q >= GW'(WORD_W - 1)));

    // R6
    start_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> word_vld);

    // R7
    h_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(h_flag) |-> word_start);

    // R8
    h_bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(h_flag) |-> !$past(bypass));

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));
endmodule

// File: rtl/sdi_trs_aligner.sv
module sdi_trs_aligner #(
    parameter int WORD_W    = 10,
    parameter int PRE_WORDS = 3,
    parameter int ID_BIT    = 6,
    localparam int SAMPLE_PT = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bypass,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              word_start,
    output logic              h_flag
);
    logic              pre_hit;
    logic              cap_en;
    logic              mid_en;
    logic [WORD_W-1:0] nxt_word;

    trs_window #(.WORD_W(WORD_W), .PRE_WORDS(PRE_WORDS)) u_win (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .pre_hit(pre_hit), .nxt_word(nxt_word)
    );

    trs_bit_phase #(.WORD_W(WORD_W), .SAMPLE_PT(SAMPLE_PT)) u_phase (
        .clk(clk), .rst_n(rst_n), .pre_hit(pre_hit),
        .cap_en(cap_en), .mid_en(mid_en)
    );

    trs_word_fsm #(.WORD_W(WORD_W), .ID_BIT(ID_BIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .pre_hit(pre_hit),
        .cap_en(cap_en), .mid_en(mid_en), .nxt_word(nxt_word),
        .word_out(word_out), .word_vld(word_vld),
        .word_start(word_start), .h_flag(h_flag)
    );

    // R3
    hit_cap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_hit && cap_en));
endmodule

// File: tb/sdi_trs_aligner_tb_top.sv
module sdi_trs_aligner_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bypass = 1'b0;
    logic [9:0] word_out;
    logic       word_vld, word_start, h_flag;

    always #4 clk = ~clk;

    sdi_trs_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bypass(bypass),
        .word_out(word_out), .word_vld(word_vld),
        .word_start(word_start), .h_flag(h_flag)
    );

    int n_run = 0, n_fail = 0;
    int step_idx = 0;
    int lg_n = 0;
    int lg_t [0:1023];
    logic [9:0] lg_w [0:1023];
    bit lg_s [0:1023];
    logic exp_h = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic next_h(input logic prev, input logic [9:0] id, input bit byp);
        return byp ? prev : id[6];
    endfunction

    task automatic step(input logic b);
        @(negedge clk);
        step_idx++;
        if (word_vld && lg_n < 1024) begin
            lg_t[lg_n] = step_idx;
            lg_w[lg_n] = word_out;
            lg_s[lg_n] = word_start;
            lg_n++;
        end
        bit_in = b;
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int i = 0; i < 10; i++) step(w[i]);
    endtask

    function automatic logic [9:0] rand_word();
        return 10'(4 + ($urandom % 1016));
    endfunction

    task automatic burst(input int off, input logic [9:0] id, input bit byp, input int nw);
        logic [9:0] wq [0:15];
        int first_log, t_last, k, starts;
        bit aligned;
        aligned = (off % 10 == 0);
        bypass = byp;
        first_log = lg_n;
        for (int i = 0; i < off; i++) step((i % 7 == 6) ? 1'b1 : 1'($urandom % 2));
        for (int i = 0; i < 10; i++) step(1'b1);
        for (int i = 0; i < 20; i++) step(1'b0);
        send_word(id);
        t_last = step_idx;
        for (int j = 0; j < nw; j++) begin
            wq[j] = rand_word();
            send_word(wq[j]);
        end
        send_word(rand_word());
        send_word(rand_word());
        exp_h = next_h(exp_h, id, byp);
        k = -1; starts = 0;
        for (int i = first_log; i < lg_n; i++)
            if (lg_s[i]) begin starts++; if (k < 0) k = i; end
        chk(starts == 1, "R6 start count", starts, 1);
        if (k < 0) return;
        chk(lg_t[k] == t_last + 6, "R4 id latency", lg_t[k] - t_last, 6);
        chk(lg_w[k] == id, "R3 id word", lg_w[k], id);
        for (int j = 0; j < nw; j++) begin
            chk(lg_w[k+1+j] == wq[j], "R2 word bits", lg_w[k+1+j], wq[j]);
            chk(lg_t[k+1+j] - lg_t[k+j] == 10, "R2 spacing", lg_t[k+1+j] - lg_t[k+j], 10);
        end
        if (aligned && k > 0)
            chk(lg_t[k] - lg_t[k-1] == 10, "R5 aligned cadence", lg_t[k] - lg_t[k-1], 10);
        chk(h_flag == exp_h, byp ? "R8 h held" : "R7 h level", h_flag, exp_h);
    endtask

    task automatic finish_tb();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_tb();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(word_out == 0 && !word_vld && !word_start && !h_flag, "R1 reset state",
            {word_out, word_vld, word_start, h_flag}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0);
        chk(!word_vld && !h_flag && word_out == 0, "R1 idle after reset",
            {word_out, word_vld, h_flag}, 0);
        burst(7,  10'h2D8, 1'b0, 5);
        burst(13, 10'h2AC, 1'b0, 4);
        burst(20, 10'h2D8, 1'b0, 4);
        burst(0,  10'h2AC, 1'b0, 3);
        burst(3,  10'h2D8, 1'b1, 4);
        burst(10, 10'h2D8, 1'b0, 3);
        burst(18, 10'h2AC, 1'b1, 3);
        for (int r = 0; r < 6; r++)
            burst(int'($urandom % 26), ($urandom % 2) ? 10'h2D8 : 10'h2AC,
                  1'($urandom % 3 == 0), 3);
        finish_tb();
    end
endmodule